// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers up to thirteen level-sensitive interrupt requests into a pending register. A mask register filters the pending bits, and an 8-bit control register per source holds a 5-bit priority and an autovector select. Every cycle the controller picks the unmasked pending source with the largest priority. It drives that source's number, a CPU interrupt level from 0 to 7 and an 8-bit exception vector. In the default build, timer requests arrive on sources 9 and 10 and serial-port requests on sources 12 and 13.

Software programs the mask, the control registers and the per-source vector registers through three plain write strobes. The arbitration result is combinational from the stored state. A request edge or a register write therefore appears on the outputs in the cycle after the clock edge that captures it. The block accepts a write in any cycle and never stalls, so no ready or back-pressure signal exists at its edge. The CPU acknowledge cycle and external pin decoding belong to the surrounding logic.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Bit i of `irq_req` and `pend_o` belongs to source i+1. Each clock edge copies `irq_req` into the pending register, so a request that rises sets its bit and a request that falls clears it.
- R2: A source is active only when its pending bit is 1 and its mask bit is 0. A mask bit of 1 keeps the source out of arbitration.
- R3: Among the active sources, the one whose control bits [4:0] form the largest value wins. `irq_src` reports its number, 1 to 13.
- R4: When active sources tie on priority, the lowest-numbered one wins.
- R5: `irq_level` equals control bits [4:2] of the winner. A source whose priority field is 0 never wins.
- R6: When control bit 7 of the winner is 1, `irq_vector` equals 24 plus `irq_level`.
- R7: When control bit 7 of the winner is 0, `irq_vector` equals the winner's vector register.
- R8: When no source wins, `irq_src`, `irq_level` and `irq_vector` are all 0.
- R9: Reset sets every mask bit to 1 and clears the pending, control and vector registers. Requests held during and after reset therefore give level 0.
- R10: A write to the mask, a control register or a vector register changes the outputs in the cycle after the write edge.
- R11: A control or vector write whose index is 0 or greater than 13 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 13 | Request lines; bit i is source i+1 |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 13 | New mask, 1 = masked |
| ctl_we | input | 1 | Write strobe for a control register |
| ctl_idx | input | 4 | Source number for the control write |
| ctl_wdata | input | 8 | Control value: [7] autovector, [4:0] priority |
| vec_we | input | 1 | Write strobe for a vector register |
| vec_idx | input | 4 | Source number for the vector write |
| vec_wdata | input | 8 | Vector value |
| pend_o | output | 13 | Pending register |
| irq_src | output | 4 | Winning source number, 0 when none |
| irq_level | output | 3 | CPU interrupt level |
| irq_vector | output | 8 | Exception vector for the winner |

## Verification
The bench builds the block with its default parameters: thirteen sources, a 5-bit priority and 8-bit control and vector registers. With these defaults the 4-bit index can address 0, 14 and 15, so the bench can show that out-of-range writes are dropped. The 5-bit priority space is small enough for random traffic to produce frequent ties, as well as sources that are pending and unmasked but have priority 0. The bench also covers transitions between the autovector and stored-vector cases under the same winner.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned CTL_W     = 8;
  localparam int unsigned VEC_W     = 8;
  localparam int unsigned LVL_W     = 3;
  localparam int unsigned AUTO_BIT  = 7;
  localparam int unsigned AUTO_BASE = 24;

  typedef logic [CTL_W-1:0] ctl_t;
  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs
  import prio_irq_pkg::*;
#(
  parameter int NSRC  = 13,
  parameter int SRC_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       irq_req,
  input  logic                  mask_we,
  input  logic [NSRC-1:0]       mask_wdata,
  input  logic                  ctl_we,
  input  logic [SRC_W-1:0]      ctl_idx,
  input  ctl_t                  ctl_wdata,
  input  logic                  vec_we,
  input  logic [SRC_W-1:0]      vec_idx,
  input  vec_t                  vec_wdata,
  output logic [NSRC-1:0]       pend_q,
  output logic [NSRC-1:0]       mask_q,
  output ctl_t [NSRC-1:0]       ctl_q,
  output vec_t [NSRC-1:0]       vec_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      pend_q <= irq_req;
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q[i] <= '0;
        vec_q[i] <= '0;
      end else begin
        if (ctl_we && ctl_idx == SRC_W'(i + 1)) ctl_q[i] <= ctl_wdata;
        if (vec_we && vec_idx == SRC_W'(i + 1)) vec_q[i] <= vec_wdata;
      end
    end
  end

  // Pending register tracks the request lines one edge later.
  assert_pend_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pend_q == $past(irq_req));
  // A dropped mask write leaves the mask untouched.
  assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import prio_irq_pkg::*;
#(
  parameter int NSRC   = 13,
  parameter int SRC_W  = 4,
  parameter int PRIO_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   active,
  input  ctl_t [NSRC-1:0]   ctl,
  output logic [SRC_W-1:0]  win_src,
  output logic [PRIO_W-1:0] win_prio
);
  always_comb begin
    win_src  = '0;
    win_prio = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (active[i] && ctl[i][PRIO_W-1:0] > win_prio) begin
        win_prio = ctl[i][PRIO_W-1:0];
        win_src  = SRC_W'(i + 1);
      end
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    // No active source outranks the winner.
    assert_no_higher_R3: assert property (@(posedge clk) disable iff (!rst_n)
      active[i] |-> ctl[i][PRIO_W-1:0] <= win_prio);
    // A lower-numbered active source never ties with the winner.
    assert_tie_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (active[i] && win_src > SRC_W'(i + 1)) |-> ctl[i][PRIO_W-1:0] < win_prio);
  end
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
  import prio_irq_pkg::*;
#(
  parameter int NSRC   = 13,
  parameter int SRC_W  = 4,
  parameter int PRIO_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] win_src,
  input  ctl_t [NSRC-1:0]  ctl,
  input  vec_t [NSRC-1:0]  vec,
  output lvl_t             level,
  output vec_t             vector
);
  ctl_t sel_ctl;
  vec_t sel_vec;

  always_comb begin
    sel_ctl = '0;
    sel_vec = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (win_src == SRC_W'(i + 1)) begin
        sel_ctl = ctl[i];
        sel_vec = vec[i];
      end
    end
  end

  always_comb begin
    level  = sel_ctl[PRIO_W-1 -: LVL_W];
    if (win_src == '0)            vector = '0;
    else if (sel_ctl[AUTO_BIT])   vector = vec_t'(AUTO_BASE) + vec_t'(level);
    else                          vector = sel_vec;
  end

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    win_src == '0 |-> (level == '0 && vector == '0));
  assert_auto_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_src != '0 && sel_ctl[AUTO_BIT]) |-> (vector >= vec_t'(AUTO_BASE) && vector <= vec_t'(AUTO_BASE + 7)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NSRC   = 13,
  parameter int PRIO_W = 5,
  parameter int SRC_W  = $clog2(NSRC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  irq_req,
  input  logic             mask_we,
  input  logic [NSRC-1:0]  mask_wdata,
  input  logic             ctl_we,
  input  logic [SRC_W-1:0] ctl_idx,
  input  logic [7:0]       ctl_wdata,
  input  logic             vec_we,
  input  logic [SRC_W-1:0] vec_idx,
  input  logic [7:0]       vec_wdata,
  output logic [NSRC-1:0]  pend_o,
  output logic [SRC_W-1:0] irq_src,
  output logic [2:0]       irq_level,
  output logic [7:0]       irq_vector
);
  logic [NSRC-1:0]   pend_q, mask_q, active;
  ctl_t [NSRC-1:0]   ctl_q;
  vec_t [NSRC-1:0]   vec_q;
  logic [PRIO_W-1:0] win_prio;

  irq_src_regs #(.NSRC(NSRC), .SRC_W(SRC_W)) u_regs (
    .clk, .rst_n, .irq_req,
    .mask_we, .mask_wdata,
    .ctl_we, .ctl_idx, .ctl_wdata,
    .vec_we, .vec_idx, .vec_wdata,
    .pend_q, .mask_q, .ctl_q, .vec_q
  );

  assign active = pend_q & ~mask_q;
  assign pend_o = pend_q;

  irq_arbiter #(.NSRC(NSRC), .SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_arb (
    .clk, .rst_n, .active, .ctl(ctl_q),
    .win_src(irq_src), .win_prio
  );

  irq_vector_gen #(.NSRC(NSRC), .SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_vec (
    .clk, .rst_n, .win_src(irq_src), .ctl(ctl_q), .vec(vec_q),
    .level(irq_level), .vector(irq_vector)
  );

  // Any winner is an unmasked pending source.
  assert_win_unmasked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_src != '0 |-> (active[irq_src - 1'b1] && win_prio != '0));
  // A non-zero level needs a winner.
  assert_level_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level != '0 |-> irq_src != '0);
endmodule

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
  localparam int N = 13;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_req = '0, mask_wdata = '0;
  logic mask_we = 0, ctl_we = 0, vec_we = 0;
  logic [3:0] ctl_idx = '0, vec_idx = '0;
  logic [7:0] ctl_wdata = '0, vec_wdata = '0;
  logic [N-1:0] pend_o;
  logic [3:0] irq_src;
  logic [2:0] irq_level;
  logic [7:0] irq_vector;

  int checks = 0, fails = 0;
  bit done = 0, cmp_on = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (.*);

  // Reference model state, indexed by source number 1..N.
  bit m_pend[N+1], m_mask[N+1];
  int m_ctl[N+1], m_vec[N+1];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 1; s <= N; s++) begin
        m_pend[s] <= 0; m_mask[s] <= 1; m_ctl[s] <= 0; m_vec[s] <= 0;
      end
    end else begin
      for (int s = 1; s <= N; s++) begin
        m_pend[s] <= irq_req[s-1];
        if (mask_we) m_mask[s] <= mask_wdata[s-1];
        if (ctl_we && ctl_idx == s) m_ctl[s] <= ctl_wdata;
        if (vec_we && vec_idx == s) m_vec[s] <= vec_wdata;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_out(output int src, output int lvl, output int vec);
    int best = 0;
    src = 0;
    for (int s = 1; s <= N; s++)
      if (m_pend[s] && !m_mask[s] && (m_ctl[s] % 32) > best) begin
        best = m_ctl[s] % 32; src = s;
      end
    lvl = src ? best / 4 : 0;
    if (src == 0) vec = 0;
    else if (m_ctl[src] >= 128) vec = 24 + lvl;
    else vec = m_vec[src];
  endfunction

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      int s, l, v;
      model_out(s, l, v);
      check("R3/R4 src", int'(irq_src), s);
      check("R5 level", int'(irq_level), l);
      check(s == 0 ? "R8 vector" : (m_ctl[s] >= 128 ? "R6 vector" : "R7 vector"),
            int'(irq_vector), v);
    end
  end

  task automatic cyc(); @(negedge clk); #1; mask_we = 0; ctl_we = 0; vec_we = 0; endtask
  task automatic wctl(int idx, int val); ctl_we = 1; ctl_idx = 4'(idx); ctl_wdata = 8'(val); cyc(); endtask
  task automatic wvec(int idx, int val); vec_we = 1; vec_idx = 4'(idx); vec_wdata = 8'(val); cyc(); endtask
  task automatic wmask(int val); mask_we = 1; mask_wdata = N'(val); cyc(); endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    irq_req = '1;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    cyc();
    check("R9 level after reset", irq_level, 0);
    check("R9 src after reset", irq_src, 0);
    check("R1 pending follows", pend_o, 13'h1FFF);
    cmp_on = 1;
    wmask(0);
    check("R5 zero priority never wins", irq_src, 0);
    wvec(9, 8'h40);
    wctl(9, 8'h0C);
    check("R10 ctl write visible", irq_src, 9);
    check("R7 stored vector", irq_vector, 8'h40);
    check("R5 level from bits 4:2", irq_level, 3);
    wctl(12, 8'h8C);
    check("R4 tie to lower source", irq_src, 9);
    wctl(12, 8'h8D);
    check("R3 higher priority wins", irq_src, 12);
    check("R6 autovector", irq_vector, 27);
    wmask(1 << 11);
    check("R2 masked source skipped", irq_src, 9);
    irq_req[8] = 0; cyc();
    check("R1 pending clears", pend_o[8], 0);
    check("R8 no winner vector", irq_vector, 0);
    wctl(0, 8'h9F); wctl(15, 8'h9F); wctl(14, 8'h9F); wvec(0, 8'h77);
    check("R11 out of range ignored", irq_src, 0);
    irq_req[8] = 1; cyc();
    check("R11 vector 9 kept", irq_vector, 8'h40);
    for (int k = 0; k < 3000; k++) begin
      irq_req = N'($urandom);
      if ($urandom % 4 == 0) begin mask_we = 1; mask_wdata = N'($urandom) & N'($urandom); end
      if ($urandom % 3 == 0) begin ctl_we = 1; ctl_idx = 4'($urandom); ctl_wdata = 8'($urandom); end
      if ($urandom % 3 == 0) begin vec_we = 1; vec_idx = 4'($urandom); vec_wdata = 8'($urandom); end
      cyc();
    end
    cmp_on = 0;
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule